// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Switch Fabric

This block is an unbuffered multistage switch for fixed-size cells. It connects eight input ports to eight output ports. The fabric has three stages. Each stage holds four 2x2 exchange elements, and perfect-shuffle wiring sits in front of every stage. Each cell carries a 3-bit destination port number and a payload. Each element looks at one bit of the destination and steers the cell to its upper or lower output. Because of this, no routing table or central scheduler is needed, and a cell reaches the same output port from any input.

The fabric is slotted. Each stage ends in a register, so a cell crosses one stage per slot, and a new cell may enter every input in every slot. Two cells can meet at one element and ask for the same output in the same slot. One of them goes on and the other is discarded. The winner alternates between the element's two inputs. A per-input drop pulse reports each discarded cell in the same slot in which that cell would have left the fabric. Surrounding logic can therefore account for every cell it injected.

Top module: `sxf_fabric`

## Requirements
- R1: While reset is active, and after it is released until cells have crossed the fabric, all `out_valid` and `drop_o` bits are 0.
- R2: A valid cell sampled at the inputs on a clock edge appears at the outputs exactly three edges later, with its destination and payload bits unchanged.
- R3: A cell that is not dropped leaves on the output port whose index equals its 3-bit destination, whatever input it entered on.
- R4: When the eight inputs carry a cyclic shift of destinations (input i to port (i+k) mod 8, for any k), all eight cells are delivered and no drop is reported.
- R5: Every valid input cell is accounted for exactly once: it is delivered, or `drop_o[i]` for its input i pulses in the slot in which it would have been delivered. When two cells at one element want the same output, exactly one of them continues.
- R6: Stage s (s = 0, 1, 2) steers on destination bit 2-s: 0 selects the element's upper output and 1 selects the lower. Element e of stage 0 receives input e as its upper input and input e+4 as its lower input. The first conflict at an element after reset is won by the upper input, and later conflicts at that element alternate the winner.
- R7: Each output port carries at most one cell per slot. When all eight inputs send to the same port in one slot, exactly one cell is delivered and seven drops are reported.
- R8: Cells may be injected on any input in every consecutive slot, and each slot's cells are routed and arbitrated independently of the neighbouring slots.
- R9: An input whose valid bit is 0 produces no output and no drop, and does not change any element's arbitration state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 8 | Per-input cell present |
| in_dst | input | 24 | Per-input destination port, 3 bits per input, input i at bits [3i+2:3i] |
| in_data | input | 64 | Per-input payload, 8 bits per input, input i at bits [8i+7:8i] |
| out_valid | output | 8 | Per-output cell present |
| out_dst | output | 24 | Destination field of the delivered cell, 3 bits per output |
| out_data | output | 64 | Payload of the delivered cell, 8 bits per output |
| drop_o | output | 8 | Per-input pulse: a cell from input i was discarded in the fabric |

## Verification
Every result of this fabric is due on the third clock edge after the edge that samples the cell. This holds for delivered cells and for drop pulses alike. The bench drives a slot's inputs at a falling edge and computes the expected outputs and drops for that slot from the routing and arbitration rules, then holds them in a three-deep history. At each later falling edge it compares the outputs against the entry from three slots earlier, so every comparison falls half a cycle after the edge that produced the value. Arbitration state starts from a known point because a reset precedes each conflict scenario, and the bench waits three idle slots before each reset so that no result is lost.

// File: rtl/sxf_pkg.sv
`timescale 1ns/1ps
package sxf_pkg;

  // Perfect-shuffle position: rotate a line index left by one within nbits.
  function automatic int unsigned shuffle_pos(int unsigned idx, int unsigned nbits);
    int unsigned top_bit;
    int unsigned mask;
    top_bit = (idx >> (nbits - 1)) & 1;
    mask    = (1 << nbits) - 1;
    return ((idx << 1) & mask) | top_bit;
  endfunction

endpackage

// File: rtl/sxf_exchange.sv
`timescale 1ns/1ps
module sxf_exchange #(
  parameter int DW  = 3,
  parameter int PW  = 8,
  parameter int SEL = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*DW+PW:0]      up_i,
  input  logic [2*DW+PW:0]      lo_i,
  output logic [2*DW+PW:0]      up_o,
  output logic [2*DW+PW:0]      lo_o,
  output logic                  drop_v_o,
  output logic [DW-1:0]         drop_src_o
);

  localparam int CW     = 1 + DW + DW + PW;
  localparam int VB     = CW - 1;
  localparam int SRC_LO = DW + PW;
  localparam int DST_LO = PW;

  logic u_v, l_v, u_b, l_b;
  logic clash, u_keep, l_keep;
  logic prio_q, prio_d, prio_en;

  always_comb begin
    u_v    = up_i[VB];
    l_v    = lo_i[VB];
    u_b    = up_i[DST_LO + SEL];
    l_b    = lo_i[DST_LO + SEL];
    clash  = u_v & l_v & (u_b == l_b);
    u_keep = u_v & ~(clash & prio_q);
    l_keep = l_v & ~(clash & ~prio_q);
  end

  always_comb begin
    up_o = '0;
    lo_o = '0;
    if (u_keep) begin
      if (u_b) lo_o = up_i;
      else     up_o = up_i;
    end
    if (l_keep) begin
      if (l_b) lo_o = lo_i;
      else     up_o = lo_i;
    end
  end

  always_comb begin
    drop_v_o   = clash;
    drop_src_o = prio_q ? up_i[SRC_LO +: DW] : lo_i[SRC_LO +: DW];
  end

  always_comb begin
    prio_en = clash;
    prio_d  = ~prio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_q <= 1'b0;
    else if (prio_en) prio_q <= prio_d;
  end

  // R5
  cell_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({up_o[VB], lo_o[VB]}) + int'(drop_v_o)) == $countones({u_v, l_v}));

endmodule

// File: rtl/sxf_stage.sv
`timescale 1ns/1ps
module sxf_stage #(
  parameter int N   = 8,
  parameter int PW  = 8,
  parameter int STG = 0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [N*(1+2*$clog2(N)+PW)-1:0]       cells_i,
  input  logic [N-1:0]                          drop_i,
  output logic [N*(1+2*$clog2(N)+PW)-1:0]       cells_o,
  output logic [N-1:0]                          drop_o
);

  localparam int DW  = $clog2(N);
  localparam int CW  = 1 + DW + DW + PW;
  localparam int NE  = N / 2;
  localparam int SEL = DW - 1 - STG;

  logic [N*CW-1:0] shuf;
  logic [N*CW-1:0] elem_out;
  logic [NE-1:0]   ev;
  logic [DW-1:0]   esrc [NE];
  logic [N-1:0]    drop_new;
  logic [N*CW-1:0] cells_d;
  logic [N-1:0]    drop_d;

  for (genvar s = 0; s < N; s++) begin : g_shuffle
    localparam int P = int'(sxf_pkg::shuffle_pos(s, DW));
    assign shuf[P*CW +: CW] = cells_i[s*CW +: CW];
  end

  for (genvar e = 0; e < NE; e++) begin : g_elem
    sxf_exchange #(.DW(DW), .PW(PW), .SEL(SEL)) i_elem (
      .clk        (clk),
      .rst_n      (rst_n),
      .up_i       (shuf[(2*e)*CW +: CW]),
      .lo_i       (shuf[(2*e+1)*CW +: CW]),
      .up_o       (elem_out[(2*e)*CW +: CW]),
      .lo_o       (elem_out[(2*e+1)*CW +: CW]),
      .drop_v_o   (ev[e]),
      .drop_src_o (esrc[e])
    );
  end

  always_comb begin
    drop_new = '0;
    for (int e = 0; e < NE; e++) begin
      if (ev[e]) drop_new[esrc[e]] = 1'b1;
    end
  end

  always_comb begin
    cells_d = elem_out;
    drop_d  = drop_i | drop_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells_o <= '0;
      drop_o  <= '0;
    end else begin
      cells_o <= cells_d;
      drop_o  <= drop_d;
    end
  end

  // R5
  single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_i & drop_new) == '0);

endmodule

// File: rtl/sxf_fabric.sv
`timescale 1ns/1ps
module sxf_fabric #(
  parameter int N_PORTS = 8,
  parameter int PAY_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_PORTS-1:0]                in_valid,
  input  logic [N_PORTS*$clog2(N_PORTS)-1:0] in_dst,
  input  logic [N_PORTS*PAY_W-1:0]          in_data,
  output logic [N_PORTS-1:0]                out_valid,
  output logic [N_PORTS*$clog2(N_PORTS)-1:0] out_dst,
  output logic [N_PORTS*PAY_W-1:0]          out_data,
  output logic [N_PORTS-1:0]                drop_o
);

  localparam int DW = $clog2(N_PORTS);
  localparam int NS = DW;
  localparam int CW = 1 + DW + DW + PAY_W;
  localparam int VB = CW - 1;

  logic       rs_q1, rst_sn;
  logic [1:0] warm_q, warm_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rs_q1  <= 1'b1;
      rst_sn <= rs_q1;
    end
  end

  logic [N_PORTS*CW-1:0] stg_cells [NS+1];
  logic [N_PORTS-1:0]    stg_drop  [NS+1];

  for (genvar i = 0; i < N_PORTS; i++) begin : g_pack
    assign stg_cells[0][i*CW +: CW] = {in_valid[i], DW'(i),
                                       in_dst[i*DW +: DW], in_data[i*PAY_W +: PAY_W]};
  end
  assign stg_drop[0] = '0;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    sxf_stage #(.N(N_PORTS), .PW(PAY_W), .STG(s)) i_stage (
      .clk     (clk),
      .rst_n   (rst_sn),
      .cells_i (stg_cells[s]),
      .drop_i  (stg_drop[s]),
      .cells_o (stg_cells[s+1]),
      .drop_o  (stg_drop[s+1])
    );
  end

  for (genvar k = 0; k < N_PORTS; k++) begin : g_unpack
    assign out_valid[k]             = stg_cells[NS][k*CW + VB];
    assign out_dst[k*DW +: DW]      = stg_cells[NS][k*CW + PAY_W +: DW];
    assign out_data[k*PAY_W +: PAY_W] = stg_cells[NS][k*CW +: PAY_W];
  end
  assign drop_o = stg_drop[NS];

  always_comb begin
    warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) warm_q <= 2'd0;
    else         warm_q <= warm_d;
  end

  for (genvar k = 0; k < N_PORTS; k++) begin : g_route_chk
    // R3
    port_match_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      out_valid[k] |-> (out_dst[k*DW +: DW] == DW'(k)));
  end

  // R5
  cell_account_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (warm_q == 2'd3) |->
      (($countones(out_valid) + $countones(drop_o)) == $past($countones(in_valid), 3)));

endmodule

// File: tb/test_sxf_fabric.sv
`timescale 1ns/1ps
module test_sxf_fabric;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  in_valid;
  logic [23:0] in_dst;
  logic [63:0] in_data;
  logic [7:0]  out_valid;
  logic [23:0] out_dst;
  logic [63:0] out_data;
  logic [7:0]  drop_o;

  always #10 clk = ~clk;

  sxf_fabric #(.N_PORTS(8), .PAY_W(8)) i_sxf_fabric (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_data(in_data), .out_valid(out_valid), .out_dst(out_dst),
    .out_data(out_data), .drop_o(drop_o)
  );

  int errors = 0;
  int checks = 0;
  int slot_no = 0;

  logic       dv [8];
  logic [2:0] dd [8];
  logic [7:0] dp [8];
  logic       m_prio [3][4];

  logic        hv   [1:3];
  logic [7:0]  hov  [1:3];
  logic [7:0]  hdrp [1:3];
  logic [10:0] hdp  [1:3][8];
  string       htag [1:3];

  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int rotl3(int l);
    return ((l << 1) & 7) | (l >> 2);
  endfunction

  task automatic model_slot(output logic [7:0] ov, output logic [7:0] odrp,
                            output logic [10:0] odp [8]);
    int ln [8];
    int sh [8];
    ov = '0; odrp = '0;
    for (int l = 0; l < 8; l++) begin
      ln[l] = dv[l] ? l : -1;
      odp[l] = '0;
    end
    for (int s = 0; s < 3; s++) begin
      for (int l = 0; l < 8; l++) sh[rotl3(l)] = ln[l];
      for (int l = 0; l < 8; l++) ln[l] = -1;
      for (int e = 0; e < 4; e++) begin
        int u, w;
        int bu, bw;
        u = sh[2*e]; w = sh[2*e+1];
        bu = (u >= 0) ? int'(dd[u][2-s]) : 0;
        bw = (w >= 0) ? int'(dd[w][2-s]) : 0;
        if (u >= 0 && w >= 0 && bu == bw) begin
          if (!m_prio[s][e]) begin
            ln[2*e+bu] = u; odrp[w] = 1'b1;
          end else begin
            ln[2*e+bw] = w; odrp[u] = 1'b1;
          end
          m_prio[s][e] = ~m_prio[s][e];
        end else begin
          if (u >= 0) ln[2*e+bu] = u;
          if (w >= 0) ln[2*e+bw] = w;
        end
      end
    end
    for (int l = 0; l < 8; l++) begin
      if (ln[l] >= 0) begin
        ov[l]  = 1'b1;
        odp[l] = {dd[ln[l]], dp[ln[l]]};
      end
    end
  endtask

  task automatic step(string tag);
    logic [7:0]  nv, nd;
    logic [10:0] ndp [8];
    @(negedge clk);
    if (hv[3]) begin
      chk(htag[3], "out_valid", 64'(out_valid), 64'(hov[3]));
      chk(htag[3], "drop_o",    64'(drop_o),    64'(hdrp[3]));
      for (int k = 0; k < 8; k++) begin
        if (hov[3][k])
          chk(htag[3], $sformatf("port%0d dst/data", k),
              64'({out_dst[k*3 +: 3], out_data[k*8 +: 8]}), 64'(hdp[3][k]));
      end
    end
    for (int h = 3; h > 1; h--) begin
      hv[h] = hv[h-1]; hov[h] = hov[h-1]; hdrp[h] = hdrp[h-1]; htag[h] = htag[h-1];
      for (int k = 0; k < 8; k++) hdp[h][k] = hdp[h-1][k];
    end
    for (int i = 0; i < 8; i++) begin
      in_valid[i]      = dv[i];
      in_dst[i*3 +: 3] = dd[i];
      in_data[i*8 +: 8] = dp[i];
    end
    model_slot(nv, nd, ndp);
    hv[1] = 1'b1; hov[1] = nv; hdrp[1] = nd; htag[1] = tag;
    for (int k = 0; k < 8; k++) hdp[1][k] = ndp[k];
    slot_no++;
  endtask

  task automatic set_idle();
    for (int i = 0; i < 8; i++) begin
      dv[i] = 1'b0; dd[i] = '0; dp[i] = '0;
    end
  endtask

  task automatic set_cell(int i, int d);
    dv[i] = 1'b1; dd[i] = 3'(d); dp[i] = {3'(i), 5'(slot_no)};
  endtask

  task automatic flush(string tag);
    set_idle();
    repeat (3) step(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0; in_dst = '0; in_data = '0;
    set_idle();
    for (int h = 1; h <= 3; h++) hv[h] = 1'b0;
    for (int s = 0; s < 3; s++)
      for (int e = 0; e < 4; e++) m_prio[s][e] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "out_valid in reset", 64'(out_valid), 64'h0);
    chk("R1", "drop_o in reset",    64'(drop_o),    64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid after reset", 64'(out_valid), 64'h0);
    chk("R1", "drop_o after reset",    64'(drop_o),    64'h0);
  endtask

  // R4: every cyclic shift delivers all eight cells without drops
  task automatic t_shifts();
    for (int k = 0; k < 8; k++) begin
      set_idle();
      for (int i = 0; i < 8; i++) set_cell(i, (i + k) % 8);
      step("R4");
    end
    flush("R4");
  endtask

  // R2 and R3: single cells from several inputs to every port
  task automatic t_single_walk();
    for (int src = 1; src < 8; src += 3) begin
      for (int d = 0; d < 8; d++) begin
        set_idle();
        set_cell(src, d);
        step("R3");
      end
    end
    set_idle();
    set_cell(6, 5); dp[6] = 8'hA5;
    step("R2");
    flush("R2");
  endtask

  // R6: repeated conflict at stage 0 element 0 alternates the winner
  task automatic t_alternate();
    do_reset();
    for (int n = 0; n < 4; n++) begin
      set_idle();
      set_cell(0, 0);
      set_cell(4, 1);
      step("R6");
    end
    flush("R6");
  endtask

  // R7: all inputs aim at one port
  task automatic t_hotspot();
    do_reset();
    for (int n = 0; n < 3; n++) begin
      set_idle();
      for (int i = 0; i < 8; i++) set_cell(i, 3);
      step("R7");
    end
    flush("R7");
  endtask

  // R9: invalid cells neither deliver, drop nor move arbitration
  task automatic t_invalid_quiet();
    do_reset();
    for (int n = 0; n < 3; n++) begin
      set_idle();
      set_cell(0, 0);
      dd[4] = 3'd1; dp[4] = 8'hFF;
      step("R9");
    end
    set_idle();
    set_cell(0, 0);
    set_cell(4, 1);
    step("R9");
    flush("R9");
  endtask

  // R5 and R8: dense pseudo-random traffic every slot
  task automatic t_stream();
    do_reset();
    for (int n = 0; n < 60; n++) begin
      set_idle();
      for (int i = 0; i < 8; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[0] | lfsr[5]) set_cell(i, int'(lfsr[4:2]));
      end
      step((n % 2 == 0) ? "R8" : "R5");
    end
    flush("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = '0; in_dst = '0; in_data = '0;
    set_idle();
    do_reset();
    t_shifts();
    t_single_walk();
    t_alternate();
    t_hotspot();
    t_invalid_quiet();
    t_stream();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule